// File: doc/BRIEF.md
# Serial ADC Read Controller

This block drives an external 8-bit successive-approximation converter that has a single convert-start pin and a three-wire serial output. When a start command arrives, the controller runs one full cycle. It shapes the convert-start waveform for the chosen power policy and waits out the worst-case conversion time, so the byte it reads back belongs to the conversion it just started. It then issues exactly eight serial clocks, captures the data bit on each falling clock edge with the most significant bit first, and presents the byte with a one-cycle valid strobe.

Two policies are selectable per command. In stay-awake mode the convert-start low pulse is short, and the line returns high well before the conversion ends, so the converter never powers down. In sleep-between mode the line stays low through the whole conversion, so the converter powers itself down. The line is then raised again, which re-arms the serial port and starts the power-up for the next command. After every cycle the line rests high, which leaves the port armed.

All timing is given in nanoseconds together with the system clock period. Each interval becomes a cycle count rounded up, so every minimum is met.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and directly after it, cnv_o, sck_o, busy_o and result_vld_o are 0 and result_o is 0.
- R2: start_i is taken only while busy_o is 0. busy_o is 1 from the cycle after an accepted start until the result cycle. A start seen while busy_o is 1 causes no extra falling edge on cnv_o, no extra result and no change of mode. A start presented in the cycle that result_vld_o is 1 is accepted.
- R3: Every falling edge of cnv_o is preceded by at least PWRUP_CYC cycles of cnv_o high. When the line was low at the start command, that high time is exactly PWRUP_CYC.
- R4: With auto_pd_i = 0 at the start, the cnv_o low pulse lasts exactly LO_CYC cycles, so cnv_o is high when the conversion ends, CONV_CYC cycles after the falling edge.
- R5: With auto_pd_i = 1 at the start, cnv_o stays low for CONV_CYC cycles after its falling edge and is then raised.
- R6: The first rising edge of sck_o comes no sooner than CONV_CYC cycles after the falling edge of cnv_o and at least SETUP_CYC cycles after the latest rising edge of cnv_o. cnv_o stays high whenever sck_o is high and does not change at any rising edge of sck_o.
- R7: Each cycle has exactly 8 rising edges of sck_o. Every high phase lasts HALF_CYC cycles, and every low phase between pulses lasts at least HALF_CYC cycles.
- R8: sdi_i is captured at each falling edge of sck_o. The first captured bit is bit 7 of result_o and the last is bit 0.
- R9: result_vld_o is high for exactly one cycle per accepted start, and busy_o is 0 in that cycle. result_o changes only in that cycle.
- R10: Each cycle count is the ceiling of its nanosecond time divided by CLK_NS, with a minimum of 1. With CLK_NS = 12 this gives PWRUP_CYC 84, LO_CYC 2, CONV_CYC 417, SETUP_CYC 1 and HALF_CYC 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion-and-read cycle |
| auto_pd_i | input | 1 | Policy for this cycle: 1 = converter sleeps between conversions, 0 = stays awake |
| sdi_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert-start line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| result_o | output | NB | Last captured byte |
| result_vld_o | output | 1 | One-cycle strobe marking a new result_o |
| busy_o | output | 1 | High while a cycle is in progress |

## Verification
Two events can fall in the same cycle: delivering a result, which clears busy_o and pulses result_vld_o, and accepting a new start command. The bench raises start_i in exactly the cycle where it sees result_vld_o. It then checks that busy_o is set again, that result_vld_o has dropped, and that the chained cycle yields a second, correct byte under its own mode. A separate case pulses start with the opposite mode in the middle of a busy cycle. For that case the bench checks that only one falling edge of the convert-start line occurs and that the end-of-conversion level still follows the original mode.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_CNVLO,
    ST_WAITC,
    ST_SCKH,
    ST_SCKL,
    ST_DONE
  } rd_state_t;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int cyc_ceil(input int t_ns, input int clk_ns);
    int r;
    r = (t_ns + clk_ns - 1) / clk_ns;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/adc_rd_runcnt.sv
`timescale 1ns/1ps
// Saturating elapsed-cycle counter with synchronous clear.
module adc_rd_runcnt #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CAP = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != CAP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_sipo.sv
`timescale 1ns/1ps
// Serial-in parallel-out register, first bit ends up in the top position.
module adc_rd_sipo #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          din,
  output logic [NB-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= {q[NB-2:0], din};
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int NB          = 8,
  parameter int CLK_NS      = 10,
  parameter int T_PWRUP_NS  = 1000,
  parameter int T_LO_NS     = 20,
  parameter int T_CONV_NS   = 5000,
  parameter int T_SETUP_NS  = 5,
  parameter int T_HALF_NS   = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          auto_pd_i,
  input  logic          sdi_i,
  output logic          cnv_o,
  output logic          sck_o,
  output logic [NB-1:0] result_o,
  output logic          result_vld_o,
  output logic          busy_o
);
  localparam int PWRUP_CYC = cyc_ceil(T_PWRUP_NS, CLK_NS);
  localparam int LO_CYC    = cyc_ceil(T_LO_NS, CLK_NS);
  localparam int CONV_CYC  = cyc_ceil(T_CONV_NS, CLK_NS);
  localparam int SETUP_CYC = cyc_ceil(T_SETUP_NS, CLK_NS);
  localparam int HALF_CYC  = cyc_ceil(T_HALF_NS, CLK_NS);
  localparam int M1        = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int M2        = (LO_CYC > SETUP_CYC) ? LO_CYC : SETUP_CYC;
  localparam int M3        = (M2 > HALF_CYC) ? M2 : HALF_CYC;
  localparam int MAXC      = (M1 > M3) ? M1 : M3;
  localparam int CNT_W     = $clog2(MAXC + 1);
  localparam int BIT_W     = $clog2(NB);
  localparam int NCNT      = 3;
  localparam int IX_HI     = 0;  // cycles convert-start has been high
  localparam int IX_CV     = 1;  // cycles since convert-start fell
  localparam int IX_PH     = 2;  // cycles in the current clock phase

  rd_state_t             state;
  logic                  cnv_q, sck_q, busy_q, vld_q, auto_q;
  logic [NB-1:0]         res_q;
  logic [BIT_W-1:0]      bit_q;
  logic [NB-1:0]         sh_q;
  logic [NCNT-1:0]       run_clr;
  logic [CNT_W-1:0]      run_q [NCNT];
  logic                  pwr_ok, lo_ok, conv_ok, setup_ok, ph_done, go_read, sample_en;

  assign pwr_ok   = run_q[IX_HI] >= CNT_W'(PWRUP_CYC - 1);
  assign setup_ok = run_q[IX_HI] >= CNT_W'(SETUP_CYC - 1);
  assign lo_ok    = run_q[IX_CV] >= CNT_W'(LO_CYC - 1);
  assign conv_ok  = run_q[IX_CV] >= CNT_W'(CONV_CYC - 1);
  assign ph_done  = run_q[IX_PH] >= CNT_W'(HALF_CYC - 1);
  assign go_read  = (state == ST_WAITC) && conv_ok && setup_ok;
  assign sample_en = (state == ST_SCKH) && ph_done;

  assign run_clr[IX_HI] = !cnv_q;
  assign run_clr[IX_CV] = (state == ST_PWRUP) && pwr_ok;
  assign run_clr[IX_PH] = go_read || (((state == ST_SCKH) || (state == ST_SCKL)) && ph_done);

  for (genvar g = 0; g < NCNT; g++) begin : g_run
    adc_rd_runcnt #(.W(CNT_W), .MAX(MAXC)) u_run (
      .clk (clk),
      .rst (rst),
      .clr (run_clr[g]),
      .cnt (run_q[g])
    );
  end

  adc_rd_sipo #(.NB(NB)) u_sipo (
    .clk (clk),
    .rst (rst),
    .en  (sample_en),
    .din (sdi_i),
    .q   (sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnv_q  <= 1'b0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      auto_q <= 1'b0;
      res_q  <= '0;
      bit_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          busy_q <= 1'b1;
          auto_q <= auto_pd_i;
          cnv_q  <= 1'b1;
          state  <= ST_PWRUP;
        end
        ST_PWRUP: if (pwr_ok) begin
          cnv_q <= 1'b0;
          state <= ST_CNVLO;
        end
        ST_CNVLO: if (auto_q ? conv_ok : lo_ok) begin
          cnv_q <= 1'b1;
          state <= ST_WAITC;
        end
        ST_WAITC: if (go_read) begin
          sck_q <= 1'b1;
          bit_q <= '0;
          state <= ST_SCKH;
        end
        ST_SCKH: if (ph_done) begin
          sck_q <= 1'b0;
          bit_q <= bit_q + 1'b1;
          state <= (bit_q == BIT_W'(NB - 1)) ? ST_DONE : ST_SCKL;
        end
        ST_SCKL: if (ph_done) begin
          sck_q <= 1'b1;
          state <= ST_SCKH;
        end
        ST_DONE: begin
          res_q  <= sh_q;
          vld_q  <= 1'b1;
          busy_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o        = cnv_q;
  assign sck_o        = sck_q;
  assign busy_o       = busy_q;
  assign result_vld_o = vld_q;
  assign result_o     = res_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
module adc_rd_ctrl_chk #(
  parameter int NB    = 8,
  parameter int PWRUP = 1,
  parameter int HALF  = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cnv_o,
  input logic          sck_o,
  input logic          busy_o,
  input logic          result_vld_o,
  input logic [NB-1:0] result_o
);
  int   cnv_run, shi_run, slo_run, rise_cnt;
  logic cnv_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_run <= 0; shi_run <= 0; slo_run <= 0; rise_cnt <= 0;
      cnv_d <= 1'b0; sck_d <= 1'b0;
    end else begin
      cnv_d   <= cnv_o;
      sck_d   <= sck_o;
      cnv_run <= cnv_o ? ((cnv_run < 1000000) ? cnv_run + 1 : cnv_run) : 0;
      shi_run <= sck_o ? ((shi_run < 1000000) ? shi_run + 1 : shi_run) : 0;
      slo_run <= !sck_o ? ((slo_run < 1000000) ? slo_run + 1 : slo_run) : 0;
      if (cnv_d && !cnv_o) rise_cnt <= 0;
      else if (sck_o && !sck_d) rise_cnt <= rise_cnt + 1;
    end
  end

  p_pwrup_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_o) |-> cnv_run >= PWRUP);
  p_sck_under_cnv_r6: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> cnv_o);
  p_cnv_steady_at_sck_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> ($past(cnv_o) && cnv_o));
  p_sck_high_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sck_o) |-> shi_run >= HALF);
  p_sck_low_len_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(sck_o) && rise_cnt != 0) |-> slo_run >= HALF);
  p_eight_clocks_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> rise_cnt < NB);
  p_fall_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_o) |-> busy_o);
  p_vld_single_r9: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |=> !result_vld_o);
  p_vld_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> !busy_o);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !result_vld_o |-> $stable(result_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.NB(NB), .PWRUP(PWRUP_CYC), .HALF(HALF_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cnv_o        (cnv_o),
  .sck_o        (sck_o),
  .busy_o       (busy_o),
  .result_vld_o (result_vld_o),
  .result_o     (result_o)
);

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;
  localparam int CLK_NS    = 12;
  localparam int EXP_PWRUP = (1000 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_LO    = (20 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_CONV  = (5000 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_SETUP = (5 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_HALF  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int NVEC      = 8;
  // {auto_pd, byte the converter delivers == expected result}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h5A},
    {1'b0, 8'h80}, {1'b1, 8'h01}, {1'b1, 8'h7E}, {1'b0, 8'hC3}
  };

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0, auto_pd = 1'b0, sdi = 1'b0;
  logic       cnv, sck, vld, busy;
  logic [7:0] result;
  logic [7:0] adc_val = 8'h00;

  int nchk = 0, nfail = 0;
  int nfall = 0, nsrise = 0, nvld = 0;
  int hi_run = 0, lo_run = 0, shi_run = 0, slo_run = 0, since = 0;
  int hi_before = 0, lo_width = 0, f2s = 0, r2s = 0, min_hi = 0, min_lo = 0, bidx = 0;
  int fb = 0, rb = 0, vb = 0;
  logic eoc_lvl = 1'b0, got_rise = 1'b0, cnv_p = 1'b0, sck_p = 1'b0;
  logic [7:0] conv_val = 8'h00, out_reg = 8'h00;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  adc_rd_ctrl #(.NB(8), .CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst(rst), .start_i(start), .auto_pd_i(auto_pd), .sdi_i(sdi),
    .cnv_o(cnv), .sck_o(sck), .result_o(result), .result_vld_o(vld), .busy_o(busy)
  );

  // Converter model and timing monitor, evaluated mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (cnv && !cnv_p) begin lo_width = lo_run; bidx = 0; end
      if (!cnv && cnv_p) begin
        hi_before = hi_run; nfall++; since = 0; conv_val = adc_val;
        got_rise = 1'b0; min_hi = 99999; min_lo = 99999;
      end
      if (since < 1000000) since++;
      if (since == EXP_CONV) begin eoc_lvl = cnv; out_reg = conv_val; end
      if (sck && !sck_p) begin
        nsrise++;
        if (!got_rise) begin got_rise = 1'b1; f2s = since - 1; r2s = hi_run; end
        else if (slo_run < min_lo) min_lo = slo_run;
        if (bidx < 8) begin sdi = out_reg[7 - bidx]; bidx++; end
      end
      if (!sck && sck_p && shi_run < min_hi) min_hi = shi_run;
      hi_run  = cnv ? hi_run + 1 : 0;
      lo_run  = cnv ? 0 : lo_run + 1;
      shi_run = sck ? shi_run + 1 : 0;
      slo_run = sck ? 0 : slo_run + 1;
      cnv_p = cnv; sck_p = sck;
      if (vld) nvld++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic launch(input bit a, input logic [7:0] v);
    adc_val = v; auto_pd = a;
    fb = nfall; rb = nsrise; vb = nvld;
    start = 1'b1; tick(); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accepted start", busy, 1);
  endtask

  task automatic finish_txn(input bit a, input logic [7:0] v, input bit chain,
                            input bit na, input logic [7:0] nv);
    int n;
    n = 0;
    while (!vld && n < 3000) begin tick(); n++; end
    chk(vld == 1'b1, "R9 result strobe seen", vld, 1);
    chk(result == v, "R8 captured byte MSB first", result, v);
    chk(busy == 1'b0, "R9 busy clear with strobe", busy, 0);
    chk(nvld - vb == 1, "R9 one strobe per start", nvld - vb, 1);
    chk(nfall - fb == 1, "R2 one convert-start fall per cycle", nfall - fb, 1);
    chk(nsrise - rb == 8, "R7 eight serial clocks", nsrise - rb, 8);
    chk(hi_before >= EXP_PWRUP, "R3 high time before fall", hi_before, EXP_PWRUP);
    if (a) begin
      chk(eoc_lvl == 1'b0, "R5 low at conversion end", eoc_lvl, 0);
      chk(lo_width >= EXP_CONV, "R5 low held through conversion", lo_width, EXP_CONV);
    end else begin
      chk(eoc_lvl == 1'b1, "R4 high at conversion end", eoc_lvl, 1);
      chk(lo_width == EXP_LO, "R4 low pulse width", lo_width, EXP_LO);
    end
    chk(f2s >= EXP_CONV, "R6 read waits conversion", f2s, EXP_CONV);
    chk(r2s >= EXP_SETUP, "R6 setup after rise", r2s, EXP_SETUP);
    chk(min_hi == EXP_HALF, "R7 high phase", min_hi, EXP_HALF);
    chk(min_lo >= EXP_HALF, "R7 low phase", min_lo, EXP_HALF);
    if (chain) begin
      adc_val = nv; auto_pd = na;
      fb = nfall; rb = nsrise; vb = nvld;
      start = 1'b1;
    end
    tick();
    start = 1'b0;
    chk(vld == 1'b0, "R9 strobe lasts one cycle", vld, 0);
    if (chain) chk(busy == 1'b1, "R2 start in strobe cycle accepted", busy, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    repeat (4) tick();
    // R1: reset state
    chk(cnv == 1'b0, "R1 cnv in reset", cnv, 0);
    chk(sck == 1'b0 && busy == 1'b0 && vld == 1'b0, "R1 controls in reset",
        {sck, busy, vld}, 0);
    chk(result == 8'h00, "R1 result in reset", result, 0);
    rst = 1'b0;
    tick();
    chk(cnv == 1'b0 && busy == 1'b0, "R1 idle after reset", {cnv, busy}, 0);

    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i][8], VEC[i][7:0]);
      if (i == 0) begin
        while (nfall == fb) tick();
        chk(hi_before == EXP_PWRUP, "R10 power-up count rounded up", hi_before, EXP_PWRUP);
      end
      finish_txn(VEC[i][8], VEC[i][7:0], 1'b0, 1'b0, 8'h00);
      repeat (3) tick();
    end

    // R2: start with the other mode in the middle of a busy cycle is ignored
    launch(1'b0, 8'h3C);
    repeat (40) tick();
    auto_pd = 1'b1; start = 1'b1; tick(); start = 1'b0;
    finish_txn(1'b0, 8'h3C, 1'b0, 1'b0, 8'h00);
    repeat (3) tick();

    // R2: new start landing in the strobe cycle chains a second cycle
    launch(1'b1, 8'h96);
    finish_txn(1'b1, 8'h96, 1'b1, 1'b0, 8'h69);
    finish_txn(1'b0, 8'h69, 1'b0, 1'b0, 8'h00);
    chk(sck == 1'b0 && cnv == 1'b1, "R6 lines rest after read", {sck, cnv}, 1);

    report();
  end
endmodule